// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block sits on the host side of a parallel flash device and decides when a program or erase operation that has already been started on the device has finished. It is launched with the address it must watch and the byte it expects. For an erase it is launched with an erase flag instead, because erased cells read back as all ones. It then reads the device status byte again and again through a read port, judging each byte by its polling bit (bit 7) and its timeout bit (bit 5).

When the polling bit matches the expected bit 7, the operation is complete. The block then makes one more read to capture a full, settled data byte, because the polling bit can settle before the other bits of the same read. A raised timeout bit does not end the operation at once. The block makes one more read and judges bit 7 a second time, because bit 7 and bit 5 can change together. A parameter caps the number of status reads so that a device that never answers still ends in a result.

The read port follows valid/ready rules. The block raises `rd_valid` with a fixed `rd_addr` and holds both until the memory side raises `rd_ready`. The cycle in which both are high is the handshake, and `rd_data` is taken in that same cycle. The memory side may hold `rd_ready` low for any number of cycles. The block never withdraws a request and never has more than one read open.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `done`, `pass`, `fail` and `rd_valid` are low and `final_data` is 0.
- R2: `start` is accepted only while no operation is open; the block then latches `op_addr`, and every read of that operation uses it. A `start` pulse that arrives while an operation is open has no effect on addresses, read count or result.
- R3: `rd_valid` rises in the cycle after `start` is accepted. It stays high with `rd_addr` stable until the handshake (`rd_valid` and `rd_ready` both high). After a handshake that does not end the operation, `rd_valid` stays high for the next read.
- R4: A status read whose bit 7 equals the expected bit 7 is followed by exactly one more read. That read ends the operation with a pass.
- R5: A status read whose bit 7 differs from the expected bit 7 and whose bit 5 is 0 is followed by another status read.
- R6: A status read whose bit 7 differs and whose bit 5 is 1 is followed by exactly one recheck read. If the recheck's bit 7 matches, the final read of R4 follows and the result is pass. Otherwise the operation ends with a fail and no further reads.
- R7: With `op_erase` high at start, the expected bit 7 is 1 whatever `op_data` holds. With `op_erase` low, it is `op_data[7]`.
- R8: If the MAX_POLLS-th status read of one operation has bit 7 differing and bit 5 at 0, the operation ends with a fail and no further reads. A timeout bit on that last read still gets its recheck (R6). The count restarts with each operation.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake that ends the operation. In that cycle exactly one of `pass` and `fail` is high and `rd_valid` is low. Outside that cycle `pass` and `fail` are low.
- R10: On a pass, `final_data` takes the byte returned by the final read and shows it from the `done` cycle onward. On a fail, `final_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch a wait; taken only when idle |
| op_erase | input | 1 | High: wait for an erase (expected bit 7 is 1) |
| op_addr | input | AW | Address to poll: program address or an address in an erasing sector |
| op_data | input | DW | Byte that was programmed |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted; `rd_data` valid in the same cycle |
| rd_addr | output | AW | Read address, stable while `rd_valid` is high |
| rd_data | input | DW | Read data, sampled at the handshake |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | High with `done` when the operation succeeded |
| fail | output | 1 | High with `done` when the operation failed or ran out of polls |
| final_data | output | DW | Settled byte captured on a pass |

## Verification
`rd_valid` and `rd_addr` are due in the cycle after the edge that accepts `start` and after every handshake. `done`, `pass`, `fail` and `final_data` are due in the cycle after the edge of the deciding handshake. The bench keeps a behavioural reference model that steps at each rising edge on the same inputs the design sees. It compares every output in the middle of the following low phase, so each value is judged in exactly the cycle it is due. Each operation is also checked at its end: the result and captured byte must match, and the number of reads consumed from the scripted memory must equal the number the requirements call for.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  // Operation phase of the poller.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_POLL  = 2'd1,
    PH_RECHK = 2'd2,
    PH_FINAL = 2'd3
  } phase_e;

  // Judgement of one status byte.
  typedef enum logic [1:0] {
    VD_BUSY  = 2'd0,
    VD_MATCH = 2'd1,
    VD_TMO   = 2'd2
  } verdict_e;
endpackage

// File: rtl/status_judge.sv
module status_judge
  import flash_poll_pkg::*;
#(
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TMO_BIT  = 5
) (
  input  logic [DW-1:0] status,
  input  logic          exp_bit,
  output verdict_e      verdict
);
  always_comb begin
    if (status[POLL_BIT] == exp_bit) verdict = VD_MATCH;
    else if (status[TMO_BIT])        verdict = VD_TMO;
    else                             verdict = VD_BUSY;
  end
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_POLLS - 1);

  logic [CW-1:0] used;

  always_ff @(posedge clk) begin
    if (!rst_n)     used <= '0;
    else if (clear) used <= '0;
    else if (step)  used <= used + 1'b1;
  end

  // The read now in flight is the last one the budget allows.
  assign last = (used == LAST_IDX);
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import flash_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     rd_fire,
  input  verdict_e verdict,
  input  logic     budget_last,
  output phase_e   phase,
  output logic     take,
  output logic     budget_step,
  output logic     end_pass,
  output logic     end_fail
);
  phase_e nxt;

  always_comb begin
    nxt         = phase;
    take        = 1'b0;
    budget_step = 1'b0;
    end_pass    = 1'b0;
    end_fail    = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        take = 1'b1;
        nxt  = PH_POLL;
      end
      PH_POLL: if (rd_fire) begin
        unique case (verdict)
          VD_MATCH: nxt = PH_FINAL;
          VD_TMO:   nxt = PH_RECHK;
          default: begin
            if (budget_last) begin
              end_fail = 1'b1;
              nxt      = PH_IDLE;
            end else begin
              budget_step = 1'b1;
            end
          end
        endcase
      end
      PH_RECHK: if (rd_fire) begin
        if (verdict == VD_MATCH) nxt = PH_FINAL;
        else begin
          end_fail = 1'b1;
          nxt      = PH_IDLE;
        end
      end
      PH_FINAL: if (rd_fire) begin
        end_pass = 1'b1;
        nxt      = PH_IDLE;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int AW        = 18,
  parameter int DW        = 8,
  parameter int MAX_POLLS = 4096,
  parameter int POLL_BIT  = 7,
  parameter int TMO_BIT   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [DW-1:0] final_data
);
  phase_e   phase;
  verdict_e verdict;
  logic     take, budget_step, budget_last, end_pass, end_fail, rd_fire;
  logic     exp_bit_q;
  logic [AW-1:0] addr_q;

  assign rd_valid = (phase != PH_IDLE);
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      exp_bit_q <= 1'b0;
    end else if (take) begin
      addr_q    <= op_addr;
      exp_bit_q <= op_erase ? 1'b1 : op_data[POLL_BIT];
    end
  end

  status_judge #(.DW(DW), .POLL_BIT(POLL_BIT), .TMO_BIT(TMO_BIT)) judge_i (
    .status  (rd_data),
    .exp_bit (exp_bit_q),
    .verdict (verdict)
  );

  poll_budget #(.MAX_POLLS(MAX_POLLS)) budget_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (take),
    .step  (budget_step),
    .last  (budget_last)
  );

  poll_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rd_fire     (rd_fire),
    .verdict     (verdict),
    .budget_last (budget_last),
    .phase       (phase),
    .take        (take),
    .budget_step (budget_step),
    .end_pass    (end_pass),
    .end_fail    (end_fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      final_data <= '0;
    end else begin
      done <= end_pass || end_fail;
      pass <= end_pass;
      fail <= end_fail;
      if (end_pass) final_data <= rd_data;
    end
  end
endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [DW-1:0] final_data
);
  // R3: an unaccepted request is held with its address
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R2: address fixed for the whole operation
  a_r2_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> $stable(rd_addr));

  // R9: done is a single-cycle strobe
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: exactly one verdict with done
  a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  // R9: no verdict outside done
  a_r9_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!pass && !fail));

  // R9: no read open in the done cycle
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_valid);

  // R10: captured byte changes only on a pass
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pass |-> $stable(final_data));
endmodule

bind flash_done_poller flash_done_poller_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .done       (done),
  .pass       (pass),
  .fail       (fail),
  .final_data (final_data)
);

// File: tb/flash_done_poller_tb_top.sv
module flash_done_poller_tb_top;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_erase = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic rd_valid, done, pass, fail;
  logic rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic [DW-1:0] final_data;

  always #10 clk = ~clk;

  flash_done_poller #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .op_addr(op_addr), .op_data(op_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .pass(pass), .fail(fail), .final_data(final_data)
  );

  // Scripted status bytes (written by stimulus only)
  logic [DW-1:0] stat [16];
  int stat_len = 0;
  int load_id = 0;
  int stall_mode = 0;
  // Read pointer (written by memory process only)
  int rd_ptr = 0;
  int seen_id = 0;

  // Counters: stimulus-side and cycle-side kept apart
  int errs_s = 0, checks_s = 0;
  int errs_c = 0, checks_c = 0;
  int cyc = 0;

  // Reference model state (written only at rising edges)
  int m_phase = 0;
  int m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic m_eb = 1'b0;
  logic m_done = 1'b0, m_pass = 1'b0, m_fail = 1'b0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (load_id != seen_id) begin
      rd_ptr = 0;
      seen_id = load_id;
    end
    if (rst_n && rd_valid && rd_ready) rd_ptr = rd_ptr + 1;
  end

  always @(posedge clk) begin
    logic hs;
    logic [DW-1:0] d;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_addr = '0; m_eb = 1'b0;
      m_done = 1'b0; m_pass = 1'b0; m_fail = 1'b0; m_data = '0;
    end else begin
      hs = (m_phase != 0) && rd_ready;
      d = rd_data;
      m_done = 1'b0; m_pass = 1'b0; m_fail = 1'b0;
      if (m_phase == 0) begin
        if (start) begin
          m_addr = op_addr;
          m_eb = op_erase ? 1'b1 : op_data[7];
          m_cnt = 0;
          m_phase = 1;
        end
      end else if (hs) begin
        if (m_phase == 1) begin
          m_cnt = m_cnt + 1;
          if (d[7] == m_eb) m_phase = 3;
          else if (d[5]) m_phase = 2;
          else if (m_cnt >= MAXP) begin
            m_phase = 0; m_done = 1'b1; m_fail = 1'b1;
          end
        end else if (m_phase == 2) begin
          if (d[7] == m_eb) m_phase = 3;
          else begin
            m_phase = 0; m_done = 1'b1; m_fail = 1'b1;
          end
        end else begin
          m_data = d;
          m_phase = 0; m_done = 1'b1; m_pass = 1'b1;
        end
      end
    end
  end

  task automatic chk_c(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks_c++;
    if (!ok) begin
      errs_c++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs_s + errs_c, checks_s + checks_c);
  endtask

  // Per-cycle comparison and memory drive, in the low phase
  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs_c++;
      checks_c++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
    if (rst_n) begin
      chk_c(rd_valid === (m_phase != 0), "R3", "rd_valid", 32'(rd_valid), 32'(m_phase != 0));
      if (m_phase != 0)
        chk_c(rd_addr === m_addr, "R2", "rd_addr", 32'(rd_addr), 32'(m_addr));
      chk_c(done === m_done, "R9", "done", 32'(done), 32'(m_done));
      chk_c(pass === m_pass, "R4", "pass", 32'(pass), 32'(m_pass));
      chk_c(fail === m_fail, "R6", "fail", 32'(fail), 32'(m_fail));
      chk_c(final_data === m_data, "R10", "final_data", 32'(final_data), 32'(m_data));
    end
    rd_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    rd_data  = (rd_ptr < stat_len) ? stat[rd_ptr] : 8'h55;
  end

  task automatic chk_s(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks_s++;
    if (!ok) begin
      errs_s++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic script_clear();
    stat_len = 0;
    load_id++;
  endtask

  task automatic script_push(input logic [DW-1:0] b);
    stat[stat_len] = b;
    stat_len++;
  endtask

  // Called at a falling edge; returns at the falling edge where done is high
  task automatic run_op(input logic er, input logic [AW-1:0] a, input logic [DW-1:0] dv,
                        input logic inject, input logic exp_pass,
                        input logic [DW-1:0] exp_final, input string req);
    int n;
    start = 1'b1; op_erase = er; op_addr = a; op_data = dv;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      if (inject && n == 3) begin
        start = 1'b1; op_addr = ~a; op_data = ~dv; op_erase = ~er;
      end
      if (inject && n == 3)
        chk_s(rd_addr === a, "R2", "address while busy", 32'(rd_addr), 32'(a));
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk_s(done === 1'b1, req, "done seen", 32'(done), 32'd1);
    chk_s(pass === exp_pass, req, "verdict pass", 32'(pass), 32'(exp_pass));
    chk_s(fail === !exp_pass, req, "verdict fail", 32'(fail), 32'(!exp_pass));
    chk_s(final_data === exp_final, req, "final byte", 32'(final_data), 32'(exp_final));
    chk_s(rd_ptr == stat_len, req, "reads consumed", 32'(rd_ptr), 32'(stat_len));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_s(done === 1'b0 && pass === 1'b0 && fail === 1'b0, "R1", "strobes in reset",
          {29'd0, done, pass, fail}, 32'd0);
    chk_s(rd_valid === 1'b0, "R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
    chk_s(final_data === 8'h00, "R1", "final_data in reset", 32'(final_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5: program, two busy polls, then match and final read
    script_clear();
    script_push(8'h85); script_push(8'h85); script_push(8'h1A); script_push(8'h5A);
    run_op(1'b0, 18'h12345, 8'h5A, 1'b0, 1'b1, 8'h5A, "R4");
    @(negedge clk);
    chk_s(done === 1'b0, "R9", "done after one cycle", 32'(done), 32'd0);

    // R7: erase with op_data 0; expected bit 7 is 1; stalled port
    stall_mode = 1;
    script_clear();
    script_push(8'h00); script_push(8'h00); script_push(8'h80); script_push(8'hFF);
    run_op(1'b1, 18'h20010, 8'h00, 1'b0, 1'b1, 8'hFF, "R7");

    // R6: timeout bit then recheck match
    stall_mode = 0;
    script_clear();
    script_push(8'h00); script_push(8'h20); script_push(8'hA0); script_push(8'hC3);
    run_op(1'b0, 18'h3FFFF, 8'h80, 1'b0, 1'b1, 8'hC3, "R6");

    // R6 R10: timeout bit then recheck mismatch; byte kept
    script_clear();
    script_push(8'h20); script_push(8'h20);
    run_op(1'b0, 18'h3FFFF, 8'h80, 1'b0, 1'b0, 8'hC3, "R6");

    // R8: budget exhausted after MAXP busy polls
    script_clear();
    for (int i = 0; i < MAXP; i++) script_push(8'h80);
    run_op(1'b0, 18'h00100, 8'h00, 1'b0, 1'b0, 8'hC3, "R8");
    repeat (3) @(negedge clk);
    chk_s(rd_valid === 1'b0, "R8", "no read after budget fail", 32'(rd_valid), 32'd0);

    // R2: start pulse while busy is ignored; stalled port; budget restarted
    stall_mode = 1;
    script_clear();
    for (int i = 0; i < MAXP - 1; i++) script_push(8'h91);
    script_push(8'h11); script_push(8'h77);
    run_op(1'b0, 18'h00400, 8'h11, 1'b1, 1'b1, 8'h77, "R2");

    // R9: back-to-back start in the done cycle, immediate match
    stall_mode = 0;
    script_clear();
    script_push(8'hFE); script_push(8'hE0);
    run_op(1'b0, 18'h0ABCD, 8'hFE, 1'b0, 1'b1, 8'hE0, "R9");

    // R8 R6: timeout bit on the last allowed poll still gets a recheck
    script_clear();
    for (int i = 0; i < MAXP - 1; i++) script_push(8'h80);
    script_push(8'hA0); script_push(8'h00); script_push(8'h3C);
    run_op(1'b0, 18'h15555, 8'h00, 1'b0, 1'b1, 8'h3C, "R8");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule